// File: doc/BRIEF.md
# Power-Good Output Sequencer

This block produces a pair of matching power-good outputs for a board. It takes two digital comparator results for the main supply, one saying the supply is above an upper threshold and one saying it has dropped below a lower threshold. It also takes a good flag from an external power supply. All three inputs may change at any time relative to the clock, so each passes through a synchronizer before the control logic sees it.

When the synchronized upper-threshold flag rises, a settling timer of `DELAY_CYCLES` clock cycles starts. The timer starts whatever the state of the external good flag. Both outputs go high once the timer has finished and the external flag is also high. If the flag was already high, this happens when the timer ends; if it arrives later, it happens when the flag arrives. Either fault drops the outputs immediately, with no timer: the supply falling below the lower threshold, or the external flag going low.

The two thresholds form a hysteresis band. Only a drop below the lower threshold clears the timer. A completed timer stays valid while the external flag comes and goes. The default delay of 6,600,000 cycles gives 33 ms at a 200 MHz clock.

Top module: `pwrgood_seq`

## Requirements
- R1: With the external good input already high and steady, both outputs go high exactly `DELAY_CYCLES`+3 rising clock edges after the upper-threshold input rises. These edges are two synchronizer stages, one edge to start the timer and `DELAY_CYCLES` timer edges.
- R2: The outputs stay low at every edge before the timer has completed, even when the external good input is high throughout.
- R3: If the external good input is still low when the timer completes, the outputs stay low. They go high 2 edges after that input rises.
- R4: When the lower-threshold input rises, both outputs are low 2 edges later, the synchronizer latency, with no further delay.
- R5: When the external good input falls while the supply is valid, the outputs are low 2 edges later. When it rises again, the outputs return high 2 edges later without a new timer run.
- R6: A drop below the lower threshold clears the timer. The outputs then stay low until a new rise of the upper-threshold input, followed by the full `DELAY_CYCLES`+3 edge sequence.
- R7: The upper-threshold input falling during the timer, while the lower-threshold input stays low, does not stop or restart the timer. The outputs rise at the same edge as in R1.
- R8: The two power-good outputs always carry the same value.
- R9: An active-low asynchronous reset forces both outputs low immediately and clears the timer and the synchronizers. After release, a held-high upper-threshold input starts a full `DELAY_CYCLES`+3 sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_above_hi_i | input | 1 | Supply is above the upper threshold (asynchronous) |
| sup_below_lo_i | input | 1 | Supply is below the lower threshold (asynchronous) |
| ext_good_i | input | 1 | External power-supply good flag (asynchronous) |
| pg_a_o | output | 1 | Power-good output, first copy |
| pg_b_o | output | 1 | Power-good output, second copy |

## Verification
Every input crosses two synchronizer flops. A fault or the arrival of the external good flag therefore shows at the outputs 2 rising edges after the input changes. A supply rise takes `DELAY_CYCLES`+3 edges, the extra edge being the one that starts the timer. The bench drives inputs on falling edges and counts rising edges from there. It samples shortly before the next falling edge. For each timed event it checks the output one edge early, expecting the old value, and again at the due edge, expecting the new one. An output that moves one cycle early or late is therefore reported.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

   typedef enum logic [1:0] {
      PGS_OFF    = 2'd0,
      PGS_TIMING = 2'd1,
      PGS_READY  = 2'd2
   } pgs_state_e;

   function automatic int pgs_cnt_width(input int cycles);
      return (cycles > 2) ? $clog2(cycles) : 1;
   endfunction

endpackage

// File: rtl/pgs_sync.sv
module pgs_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   logic [WIDTH-1:0] chain_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= '0;
               else        chain_q[0] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= '0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/pgs_supply_timer.sv
module pgs_supply_timer
   import pgs_pkg::*;
#(
   parameter int DELAY_CYCLES = 6_600_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic above_hi_s,
   input  logic below_lo_s,
   output logic ready_o,
   output logic timing_o
);

   localparam int CW = pgs_cnt_width(DELAY_CYCLES);
   localparam logic [CW-1:0] LAST = CW'(DELAY_CYCLES - 1);

   pgs_state_e       state_q, state_d;
   logic [CW-1:0]    cnt_q, cnt_d;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         PGS_OFF: begin
            cnt_d = '0;
            if (above_hi_s && !below_lo_s) state_d = PGS_TIMING;
         end
         PGS_TIMING: begin
            if (below_lo_s) begin
               state_d = PGS_OFF;
               cnt_d   = '0;
            end else if (cnt_q == LAST) begin
               state_d = PGS_READY;
               cnt_d   = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         PGS_READY: begin
            cnt_d = '0;
            if (below_lo_s) state_d = PGS_OFF;
         end
         default: begin
            state_d = PGS_OFF;
            cnt_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PGS_OFF;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign ready_o  = (state_q == PGS_READY);
   assign timing_o = (state_q == PGS_TIMING);

endmodule

// File: rtl/pgs_out_gate.sv
module pgs_out_gate #(
   parameter int NUM_OUT = 2
) (
   input  logic               ready_i,
   input  logic               good_s,
   input  logic               below_lo_s,
   output logic [NUM_OUT-1:0] pg_o
);

   logic enable;
   assign enable = ready_i & good_s & ~below_lo_s;

   generate
      for (genvar i = 0; i < NUM_OUT; i++) begin : g_copy
         assign pg_o[i] = enable;
      end
   endgenerate

endmodule

// File: rtl/pwrgood_seq.sv
module pwrgood_seq #(
   parameter int DELAY_CYCLES = 6_600_000,
   parameter int SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sup_above_hi_i,
   input  logic sup_below_lo_i,
   input  logic ext_good_i,
   output logic pg_a_o,
   output logic pg_b_o
);

   localparam int NUM_IN  = 3;
   localparam int NUM_OUT = 2;

   generate
      if (DELAY_CYCLES < 2) begin : g_bad_delay
         $error("pwrgood_seq: DELAY_CYCLES must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pwrgood_seq: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NUM_IN-1:0]  raw_in, sync_in;
   logic               above_hi_sync, below_lo_sync, good_sync;
   logic               ready, timing;
   logic [NUM_OUT-1:0] pg_vec;

   assign raw_in = {ext_good_i, sup_below_lo_i, sup_above_hi_i};

   pgs_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (raw_in),
      .sync_o  (sync_in)
   );

   assign above_hi_sync = sync_in[0];
   assign below_lo_sync = sync_in[1];
   assign good_sync     = sync_in[2];

   pgs_supply_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .above_hi_s (above_hi_sync),
      .below_lo_s (below_lo_sync),
      .ready_o    (ready),
      .timing_o   (timing)
   );

   pgs_out_gate #(.NUM_OUT(NUM_OUT)) u_gate (
      .ready_i    (ready),
      .good_s     (good_sync),
      .below_lo_s (below_lo_sync),
      .pg_o       (pg_vec)
   );

   assign pg_a_o = pg_vec[0];
   assign pg_b_o = pg_vec[1];

endmodule

// File: rtl/pgs_chk.sv
module pgs_chk (
   input logic clk,
   input logic rst_n,
   input logic lo_s,
   input logic good_s,
   input logic ready,
   input logic timing,
   input logic pg_a,
   input logic pg_b
);

   // R8
   outputs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pg_a == pg_b);

   // R4
   lo_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lo_s |-> !pg_a);

   // R3
   pg_needs_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pg_a |-> good_s);

   // R2
   ready_after_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(timing));

   // R6
   lo_clears_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lo_s |=> (!ready && !timing));

   // R2
   pg_only_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pg_b |-> ready);

endmodule

bind pwrgood_seq pgs_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .lo_s   (below_lo_sync),
   .good_s (good_sync),
   .ready  (ready),
   .timing (timing),
   .pg_a   (pg_a_o),
   .pg_b   (pg_b_o)
);

// File: tb/pwrgood_seq_tb.sv
module pwrgood_seq_tb;

   localparam int D = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hi = 1'b0, lo = 1'b0, good = 1'b0;
   logic pg_a, pg_b;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pwrgood_seq #(.DELAY_CYCLES(D), .SYNC_STAGES(2)) u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .sup_above_hi_i (hi),
      .sup_below_lo_i (lo),
      .ext_good_i     (good),
      .pg_a_o         (pg_a),
      .pg_b_o         (pg_b)
   );

   task automatic check(input string req, input logic exp);
      checks++;
      if (pg_a !== exp || pg_b !== exp) begin
         errors++;
         $display("FAIL %s t=%0t: pg_a=%b pg_b=%b expected %b", req, $time, pg_a, pg_b, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic fall_supply();
      @(negedge clk); hi = 1'b0; lo = 1'b1;
      step(4);
      @(negedge clk); lo = 1'b0;
      step(3);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; hi = 1'b0; lo = 1'b0; good = 1'b0;
      step(3);
      check("R9 reset state", 1'b0);
      @(negedge clk); rst_n = 1'b1;
      step(2);
      check("R9 after release", 1'b0);
   endtask

   task automatic t_good_first();
      @(negedge clk); good = 1'b1;
      step(4);
      @(negedge clk); hi = 1'b1;
      step(D + 2);
      check("R2 low before timer end", 1'b0);
      step(1);
      check("R1 high at timer end", 1'b1);
      check("R8 copies equal", pg_a);
   endtask

   task automatic t_good_drop();
      @(negedge clk); good = 1'b0;
      step(1);
      check("R5 still high one edge after drop", 1'b1);
      step(1);
      check("R5 low two edges after drop", 1'b0);
      @(negedge clk); good = 1'b1;
      step(1);
      check("R5 still low one edge after return", 1'b0);
      step(1);
      check("R5 high again without timer", 1'b1);
   endtask

   task automatic t_lo_drop();
      @(negedge clk); lo = 1'b1; hi = 1'b0;
      step(1);
      check("R4 still high one edge after fault", 1'b1);
      step(1);
      check("R4 low two edges after fault", 1'b0);
      @(negedge clk); lo = 1'b0;
      step(6);
      check("R6 stays low without new rise", 1'b0);
      @(negedge clk); hi = 1'b1;
      step(D + 2);
      check("R6 full timer rerun, early", 1'b0);
      step(1);
      check("R6 full timer rerun, due", 1'b1);
   endtask

   task automatic t_good_late();
      @(negedge clk); good = 1'b0;
      fall_supply();
      @(negedge clk); hi = 1'b1;
      step(D + 8);
      check("R3 held low waiting for good", 1'b0);
      @(negedge clk); good = 1'b1;
      step(1);
      check("R3 one edge after good", 1'b0);
      step(1);
      check("R3 high two edges after good", 1'b1);
   endtask

   task automatic t_hyst();
      fall_supply();
      @(negedge clk); hi = 1'b1;
      step(4);
      @(negedge clk); hi = 1'b0;
      step(D - 2);
      check("R7 early edge in band", 1'b0);
      step(1);
      check("R7 rises on schedule in band", 1'b1);
      step(3);
      check("R7 stays high in band", 1'b1);
   endtask

   task automatic t_reset_mid();
      @(negedge clk); hi = 1'b1;
      step(2);
      check("R9 high before mid reset", 1'b1);
      @(negedge clk); rst_n = 1'b0;
      #1;
      check("R9 async clear", 1'b0);
      @(negedge clk); rst_n = 1'b1;
      step(D + 2);
      check("R9 rerun early", 1'b0);
      step(1);
      check("R9 rerun due", 1'b1);
   endtask

   initial begin
      t_reset();
      t_good_first();
      t_good_drop();
      t_lo_drop();
      t_good_late();
      t_hyst();
      t_reset_mid();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule